// File: doc/BRIEF.md
# Fixed-Delay TDM Channel Switch

This block moves byte-wide channels from an incoming time-division frame to an outgoing one. A mapping table holds one entry per output channel, and each entry names the input channel to copy. The delay from input to output never depends on the mapping: a byte that enters on channel m of frame F leaves on channel n of frame F+2. The delay is therefore two frames plus (n − m) channel times. It is longer than two frames when n > m and shorter when n < m. Because the delay is fixed, bytes from different channels keep their frame grouping at the output.

Channel timing comes from `slot_en`. Each cycle with `slot_en` high is one channel time. `frame_start`, sampled with `slot_en`, marks channel 0. Captured bytes go into three rotating banks: the frame being written uses one bank, and the output reads the bank written two frames earlier. The mapping table is read one channel ahead of use.

A host port can read and write the mapping table and can read the captured-data banks. The switching path has priority, so host accesses are served only in cycles without `slot_en`.

Top module: `tsi_switch`

## Requirements
- R1: After each `slot_en` strobe for output channel n of frame F (F ≥ 2), `tx_data` carries the byte written on input channel map[n] during frame F−2. This holds from the first clock edge after that strobe.
- R2: The fixed delay of R1 holds for every mapping. This includes entries with n > m, entries with n < m, and one source feeding several outputs.
- R3: The channel index returns to 0 on a strobe that carries `frame_start` or that follows channel NCH−1. An early `frame_start` starts a new frame and a new bank at once. Entries the short frame did not write keep their older contents. Output channel 0 of a frame begun early is undefined.
- R4: Frames are counted from 0 after reset, and frame k writes bank k mod 3. In host data addressing, bits [CH_W+1:CH_W] select the bank and the low CH_W bits select the channel.
- R5: A host write with `host_dsel`=0 stores `host_wmap` as the source channel for output channel `host_addr[CH_W-1:0]`. A later host read of the same entry returns it.
- R6: A host read with `host_dsel`=1 returns the captured byte at the addressed bank and channel. A host write with `host_dsel`=1 is acknowledged and changes no stored byte.
- R7: A pending host request is granted only in a cycle where `slot_en` is low. `host_ack` is a one-cycle pulse on the edge after the grant, and `host_rdata` is valid with it.
- R8: After reset, `tx_data`, `host_ack` and `host_rdata` are 0.
- R9: `tx_data` changes only on the edge that ends a `slot_en` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | One channel time; input byte valid |
| frame_start | input | 1 | With `slot_en`: this channel is channel 0 |
| rx_data | input | DW | Incoming channel byte |
| tx_data | output | DW | Outgoing channel byte, registered |
| host_req | input | 1 | Host access request, held until `host_ack` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_dsel | input | 1 | 0 = mapping table, 1 = data banks |
| host_addr | input | CH_W+2 | Entry or {bank, channel} |
| host_wmap | input | CH_W | Source channel to store |
| host_ack | output | 1 | Access complete |
| host_rdata | output | RD_W | Read result, valid with `host_ack` |

## Verification
The properties assume that the host holds `host_req` and its fields steady until `host_ack`. They also assume that `frame_start` matters only in cycles with `slot_en`. The stimulus drives the host from one task that holds every field until the acknowledge and then drops the request, and it raises `frame_start` only in strobe cycles. Strobe gaps are random and include runs of back-to-back strobes, so that host waits and output holding are both exercised. Early frame starts are issued only at directed points.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int NBANK = 3;
  typedef logic [1:0] bank_t;

  function automatic bank_t bank_next(input bank_t b);
    return (b == bank_t'(NBANK - 1)) ? bank_t'(0) : bank_t'(b + 2'd1);
  endfunction
endpackage

// File: rtl/tsi_frame_ctl.sv
module tsi_frame_ctl
  import tsi_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot_en,
  input  logic            frame_start,
  output logic [CH_W-1:0] cur_ch,
  output logic [CH_W-1:0] la_ch,
  output bank_t           wr_bank,
  output bank_t           rd_bank
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);

  logic [CH_W-1:0] ch_q;
  bank_t           bank_q;
  logic            new_frame;

  always_comb begin
    new_frame = frame_start | (ch_q == LAST);
    cur_ch    = new_frame ? '0 : ch_q + 1'b1;
    wr_bank   = new_frame ? bank_next(bank_q) : bank_q;
    rd_bank   = bank_next(wr_bank);
    la_ch     = (cur_ch == LAST) ? '0 : cur_ch + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q   <= LAST;
      bank_q <= bank_t'(NBANK - 1);
    end else if (slot_en) begin
      ch_q   <= cur_ch;
      bank_q <= wr_bank;
    end
  end

  AST_SOF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (slot_en && frame_start) |=> (ch_q == '0));  // R3
  AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (rst)
    bank_q != 2'd3);  // R4
  AST_BANK_STEP: assert property (@(posedge clk) disable iff (rst)
    (slot_en && ch_q == LAST) |=> (bank_q == bank_next($past(bank_q))));  // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !slot_en |=> ($stable(ch_q) && $stable(bank_q)));  // R3
endmodule

// File: rtl/tsi_sdp_ram.sv
module tsi_sdp_ram #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int DW = 5,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (en) rdata <= mem[addr];
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int  NCH  = 32,
  parameter int  DW   = 8,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int HA_W = CH_W + 2,
  localparam int RD_W = (DW > CH_W) ? DW : CH_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot_en,
  input  logic            frame_start,
  input  logic [DW-1:0]   rx_data,
  output logic [DW-1:0]   tx_data,
  input  logic            host_req,
  input  logic            host_we,
  input  logic            host_dsel,
  input  logic [HA_W-1:0] host_addr,
  input  logic [CH_W-1:0] host_wmap,
  output logic            host_ack,
  output logic [RD_W-1:0] host_rdata
);
  localparam int NCOPY = 2;  // copy 0 feeds the output, copy 1 the host

  logic [CH_W-1:0] cur_ch, la_ch, cm_rd, cm_addr, src_q, src;
  bank_t           wr_bank, rd_bank;
  logic            grant, host_cm, slot_rd_q, ack_dsel_q;
  logic            re_v [NCOPY];
  logic [HA_W-1:0] ra_v [NCOPY];
  logic [DW-1:0]   rd_v [NCOPY];

  tsi_frame_ctl #(.NCH(NCH), .CH_W(CH_W)) i_frame_ctl (
    .clk(clk), .rst(rst), .slot_en(slot_en), .frame_start(frame_start),
    .cur_ch(cur_ch), .la_ch(la_ch), .wr_bank(wr_bank), .rd_bank(rd_bank)
  );

  // Switching path owns every strobe cycle; the host uses the gaps.
  assign grant   = host_req & ~slot_en & ~host_ack;
  assign host_cm = grant & ~host_dsel;
  assign cm_addr = slot_en ? la_ch : host_addr[CH_W-1:0];

  tsi_conn_mem #(.DW(CH_W), .AW(CH_W)) i_conn_mem (
    .clk(clk), .rst(rst), .en(slot_en | host_cm), .we(host_cm & host_we),
    .addr(cm_addr), .wdata(host_wmap), .rdata(cm_rd)
  );

  // The look-ahead result is kept aside so host reads cannot disturb it.
  assign src = slot_rd_q ? cm_rd : src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_rd_q  <= 1'b0;
      src_q      <= '0;
      host_ack   <= 1'b0;
      ack_dsel_q <= 1'b0;
    end else begin
      slot_rd_q <= slot_en;
      if (slot_rd_q) src_q <= cm_rd;
      host_ack  <= grant;
      if (grant) ack_dsel_q <= host_dsel;
    end
  end

  always_comb begin
    re_v[0] = slot_en;
    ra_v[0] = {rd_bank, src};
    re_v[1] = grant & host_dsel;
    ra_v[1] = host_addr;
  end

  for (genvar g = 0; g < NCOPY; g++) begin : g_dcopy
    tsi_sdp_ram #(.DW(DW), .AW(HA_W)) i_bank_ram (
      .clk(clk), .rst(rst), .we(slot_en), .waddr({wr_bank, cur_ch}),
      .wdata(rx_data), .re(re_v[g]), .raddr(ra_v[g]), .rdata(rd_v[g])
    );
  end

  assign tx_data    = rd_v[0];
  assign host_rdata = ack_dsel_q ? RD_W'(rd_v[1]) : RD_W'(cm_rd);

  AST_HOST_YIELD: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> !$past(slot_en));  // R7
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);  // R7
  AST_HOST_SERVED: assert property (@(posedge clk) disable iff (rst)
    (host_req && !slot_en && !host_ack) |=> host_ack);  // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !slot_en |=> $stable(tx_data));  // R9
endmodule

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  localparam int NCH  = 32;
  localparam int DW   = 8;
  localparam int CH_W = $clog2(NCH);
  localparam int HA_W = CH_W + 2;
  localparam int RD_W = (DW > CH_W) ? DW : CH_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_en = 1'b0, frame_start = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [DW-1:0] tx_data;
  logic host_req = 1'b0, host_we = 1'b0, host_dsel = 1'b0;
  logic [HA_W-1:0] host_addr = '0;
  logic [CH_W-1:0] host_wmap = '0;
  logic host_ack;
  logic [RD_W-1:0] host_rdata;

  tsi_switch #(.NCH(NCH), .DW(DW)) i_tsi_switch (
    .clk(clk), .rst(rst), .slot_en(slot_en), .frame_start(frame_start),
    .rx_data(rx_data), .tx_data(tx_data), .host_req(host_req),
    .host_we(host_we), .host_dsel(host_dsel), .host_addr(host_addr),
    .host_wmap(host_wmap), .host_ack(host_ack), .host_rdata(host_rdata)
  );

  always #10 clk = ~clk;  // 50 MHz

  int vec = 0, miss = 0, cyc = 0;
  int fr = -1, sl = NCH - 1, cm_ok = 1 << 30;
  int last_slot_cyc = 0, ack_cyc = 0;
  bit done = 0;
  string tag = "R1";
  logic [DW-1:0]   bm [3][NCH];
  bit              bk [3][NCH];
  logic [CH_W-1:0] cm_model [NCH];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h (frame %0d ch %0d)", req, act, exp, fr, sl);
    end
  endtask

  function automatic logic [HA_W-1:0] daddr(input int b, input int c);
    return {2'(b), CH_W'(c)};
  endfunction

  // One channel time; leaves at a negedge.
  task automatic slot(input int gap, input bit early);
    bit nf, do_chk;
    int rb, src;
    logic [DW-1:0] rx, expv, held;
    nf = early || (sl == NCH - 1);
    if (nf) begin fr++; sl = 0; end else sl++;
    rx = DW'($urandom);
    slot_en = 1'b1; frame_start = nf; rx_data = rx;
    rb = (fr + 1) % 3;
    src = int'(cm_model[sl]);
    do_chk = (fr >= cm_ok) && bk[rb][src] && !early;
    expv = bm[rb][src];
    bm[fr % 3][sl] = rx; bk[fr % 3][sl] = 1'b1;
    @(negedge clk);
    last_slot_cyc = cyc;
    if (do_chk) check(tag, int'(tx_data), int'(expv));  // R1 / R2
    if (gap > 0) begin
      slot_en = 1'b0; frame_start = 1'b0;
      held = tx_data;
      repeat (gap) @(negedge clk);
      check("R9", int'(tx_data), int'(held));
    end
  endtask

  task automatic run(input int n, input int maxgap);
    for (int i = 0; i < n; i++) begin
      int g;
      g = $urandom_range(maxgap, 0);
      if (i == n - 1 && g == 0) g = 1;
      slot(g, 1'b0);
    end
  endtask

  task automatic host(input bit we, input bit dsel, input logic [HA_W-1:0] a,
                      input logic [CH_W-1:0] wd, output logic [RD_W-1:0] rd);
    host_req = 1'b1; host_we = we; host_dsel = dsel; host_addr = a; host_wmap = wd;
    do @(negedge clk); while (!host_ack);
    rd = host_rdata; ack_cyc = cyc;
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic program_map(input int mode);
    logic [RD_W-1:0] rd;
    for (int n = 0; n < NCH; n++) begin
      logic [CH_W-1:0] v;
      if (mode == 0)      v = CH_W'(NCH - 1 - n);
      else if (n % 4 == 0) v = CH_W'(7);
      else                v = CH_W'($urandom);
      host(1'b1, 1'b0, HA_W'(n), v, rd);
      cm_model[n] = v;
    end
    cm_ok = fr + 2;
    for (int n = 0; n < NCH; n++) begin
      host(1'b0, 1'b0, HA_W'(n), '0, rd);
      check("R5", int'(rd), int'(cm_model[n]));
    end
  endtask

  task automatic data_checks();
    logic [RD_W-1:0] rd;
    host(1'b0, 1'b1, daddr(fr % 3, sl), '0, rd);
    check("R4", int'(rd), int'(bm[fr % 3][sl]));
    for (int i = 0; i < 6; i++) begin
      int b, c;
      b = $urandom_range(2, 0); c = $urandom_range(NCH - 1, 0);
      if (bk[b][c]) begin
        host(1'b1, 1'b1, daddr(b, c), CH_W'($urandom), rd);
        host(1'b0, 1'b1, daddr(b, c), '0, rd);
        check("R6", int'(rd), int'(bm[b][c]));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vec++; miss++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end

  initial begin
    logic [RD_W-1:0] rd;
    void'($urandom(32'd2417));
    for (int b = 0; b < 3; b++)
      for (int c = 0; c < NCH; c++) bk[b][c] = 1'b0;
    for (int n = 0; n < NCH; n++) cm_model[n] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8", int'(tx_data), 0);
    check("R8", int'(host_ack), 0);
    check("R8", int'(host_rdata), 0);

    // Directed reverse map: both n>m and n<m.
    tag = "R2";
    program_map(0);
    run(NCH * 5, 3);
    data_checks();

    // Broadcast of one source mixed with random entries.
    program_map(1);
    run(NCH * 5, 2);
    data_checks();

    // Random map.
    tag = "R1";
    program_map(2);
    run(NCH * 4, 3);
    data_checks();

    // Host waits through back-to-back strobes.
    fork
      begin
        for (int i = 0; i < NCH; i++) slot((i == NCH - 1) ? 1 : 0, 1'b0);
      end
      begin
        host(1'b0, 1'b0, HA_W'(3), '0, rd);
      end
    join
    check("R7", ack_cyc, last_slot_cyc + 1);
    check("R7", int'(rd), int'(cm_model[3]));

    // Early frame start mid-frame.
    run(NCH / 2 - 1, 2);
    slot(1, 1'b1);
    host(1'b0, 1'b1, daddr(fr % 3, 0), '0, rd);
    check("R3", int'(rd), int'(bm[fr % 3][0]));
    run(NCH * 4, 2);
    data_checks();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule